// File: doc/BRIEF.md
# Direct-Mapped Secondary Cache Tag Controller

This block holds the lookup and policy logic for an external, direct-mapped secondary cache with 32-byte lines. It does not hold the tags itself. For each CPU request it reads one word from an external tag RAM and compares the stored 10-bit tag with the request address. It then reports a hit or a miss and decides what the memory side must do: fetch a line, write back a dirty victim line, or pass a single word straight through. Moving the data, sequencing bursts and controlling DRAM are left to neighbouring logic.

The cache size is chosen at run time with a 3-bit code. That code sets how many address bits form the line index, so one 10-bit comparator serves every size. The write policy can be switched between write-back and write-through at any time between requests. A dirty flag is kept in the same RAM word as the tag. Software sets an upper cacheable limit and an address window whose writes are discarded. Reads in that window are still cached normally, which lets boot code run from a cacheable, write-protected copy.

A request is accepted when `cpu_req` is high while `cpu_ready` is high. The block answers with a one-cycle `rsp_valid` once all memory traffic for the request has been acknowledged. The configuration must be held steady while a request is in progress.

Top module: `l2_tag_ctrl`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `rsp_valid`, `mem_req` and `tag_we` are 0.
- R2: Size codes 1, 2, 3 and 4 select 256 KB, 512 KB, 1 MB and 2 MB, giving an index width iw = 12 + code. The index is address bits [5 +: iw] and the tag is the next 10 bits [5+iw +: 10]. The tag RAM word is {valid bit 11, dirty bit 10, tag bits 9:0}. `tag_re` and `tag_addr` (the index) appear combinationally in the cycle a request is accepted, and `tag_rdata` is expected one cycle later.
- R3: A read hit produces `rsp_valid` with `rsp_hit`=1 two cycles after acceptance, with no memory request and no tag write.
- R4: A read miss on a clean or invalid line issues a fill (`mem_op`=2) at the line-aligned address. After the acknowledge, the block writes {valid=1, dirty=0, request tag} and responds with `rsp_hit`=0.
- R5: A read miss on a valid dirty line first issues a victim write-back (`mem_op`=3) at the address rebuilt from the stored tag and the index. Only after that acknowledge does it issue the fill.
- R6: In write-back mode, a write hit writes the tag word with the dirty bit set and issues no memory request.
- R7: In write-through mode, a write hit issues a single write (`mem_op`=1) at the full address and does not write the tag RAM.
- R8: A cacheable write miss issues a single write (`mem_op`=1) and never allocates a line.
- R9: A write with wp_lo <= address < wp_hi is discarded: no tag write and no memory request. Reads in that window behave normally.
- R10: An access is non-cacheable when the size code is 0 (or above 4), when the address is at or above `cfg_cache_lim`, or when address bits at and above 15+iw are not all zero. A non-cacheable read issues a single read (`mem_op`=0), a non-cacheable write issues `mem_op`=1, neither writes the tag RAM, and `rsp_hit` is 0.
- R11: `mem_req` stays high with `mem_op` and `mem_addr` unchanged until the cycle in which `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_size | input | 3 | Cache size code: 0 disabled, 1..4 = 256 KB..2 MB |
| cfg_wb | input | 1 | 1 = write-back, 0 = write-through |
| cfg_cache_lim | input | 32 | Addresses below this value may be cached |
| cfg_wp_lo | input | 32 | Lower bound (inclusive) of the write-protected window |
| cfg_wp_hi | input | 32 | Upper bound (exclusive) of the write-protected window |
| cpu_req | input | 1 | Request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_ready | output | 1 | Block is idle and can accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Lookup hit, valid with `rsp_valid` |
| tag_addr | output | 16 | Tag RAM index |
| tag_re | output | 1 | Tag RAM read strobe |
| tag_rdata | input | 12 | Tag RAM read word, one cycle after `tag_re` |
| tag_we | output | 1 | Tag RAM write strobe |
| tag_wdata | output | 12 | Tag RAM write word |
| mem_req | output | 1 | Memory-side request, held until acknowledged |
| mem_op | output | 2 | 0 single read, 1 single write, 2 line fill, 3 victim write-back |
| mem_addr | output | 32 | Memory-side address |
| mem_ack | input | 1 | Memory-side acknowledge |

## Verification
The hardest case to reach is a read miss that lands on a valid dirty line. It needs a write-back-mode write hit on one tag, followed by a read of a different tag that maps to the same index, all under the same size code. The random stimulus draws addresses from a handful of indices and tags, including the lowest and highest index. This makes collisions, dirtying and later evictions frequent under every size code. Write-back and write-through mode are mixed from one request to the next, and the write-protect window and cacheable limit are switched on and off. A directed sequence builds the evict-then-fill case explicitly, and the memory acknowledge arrives after a random delay of zero to two cycles.

// File: rtl/l2_pkg.sv
package l2_pkg;
  localparam int L2_TAG_W = 10;
  localparam int L2_OFS_W = 5;
  localparam int L2_WORD_W = L2_TAG_W + 2;

  typedef struct packed {
    logic                valid;
    logic                dirty;
    logic [L2_TAG_W-1:0] tag;
  } tag_word_t;

  typedef enum logic [1:0] {
    MOP_RD    = 2'd0,
    MOP_WR    = 2'd1,
    MOP_FILL  = 2'd2,
    MOP_EVICT = 2'd3
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_MRD,
    ST_MWR,
    ST_RESP
  } seq_st_e;
endpackage

// File: rtl/l2_addr_split.sv
module l2_addr_split
  import l2_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MIN_IW = 13,
  parameter int NSIZE  = 4,
  localparam int MAX_IW = MIN_IW + NSIZE - 1,
  localparam int SZ_W   = $clog2(NSIZE + 1)
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SZ_W-1:0]     size,
  input  logic [ADDR_W-1:0]   lim,
  input  logic [ADDR_W-1:0]   wp_lo,
  input  logic [ADDR_W-1:0]   wp_hi,
  input  logic [L2_TAG_W-1:0] vtag,
  output logic [MAX_IW-1:0]   idx,
  output logic [L2_TAG_W-1:0] tag,
  output logic [ADDR_W-1:0]   line_addr,
  output logic [ADDR_W-1:0]   vict_addr,
  output logic                cacheable,
  output logic                wprot
);
  logic [NSIZE-1:0][MAX_IW-1:0]   idx_v;
  logic [NSIZE-1:0][L2_TAG_W-1:0] tag_v;
  logic [NSIZE-1:0][ADDR_W-1:0]   va_v;
  logic [NSIZE-1:0]               reach_v;
  logic                           reach_ok;

  // one slice per supported size; the comparator input is picked afterwards
  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int IW  = MIN_IW + g;
    localparam int TOP = L2_OFS_W + IW + L2_TAG_W;
    assign idx_v[g] = MAX_IW'(addr[L2_OFS_W +: IW]);
    assign tag_v[g] = addr[L2_OFS_W + IW +: L2_TAG_W];
    assign va_v[g]  = ADDR_W'({vtag, addr[L2_OFS_W +: IW], {L2_OFS_W{1'b0}}});
    if (TOP < ADDR_W) begin : g_reach
      assign reach_v[g] = (addr[ADDR_W-1:TOP] == '0);
    end else begin : g_full
      assign reach_v[g] = 1'b1;
    end
  end

  always_comb begin
    idx       = '0;
    tag       = '0;
    vict_addr = '0;
    reach_ok  = 1'b0;
    for (int g = 0; g < NSIZE; g++) begin
      if (size == SZ_W'(g + 1)) begin
        idx       = idx_v[g];
        tag       = tag_v[g];
        vict_addr = va_v[g];
        reach_ok  = reach_v[g];
      end
    end
  end

  assign line_addr = {addr[ADDR_W-1:L2_OFS_W], {L2_OFS_W{1'b0}}};
  assign cacheable = reach_ok && (addr < lim);
  assign wprot     = (addr >= wp_lo) && (addr < wp_hi);
endmodule

// File: rtl/l2_tag_cmp.sv
module l2_tag_cmp
  import l2_pkg::*;
(
  input  tag_word_t           word,
  input  logic [L2_TAG_W-1:0] tag,
  output logic                hit,
  output logic                vdirty
);
  logic match;

  assign match  = (word.tag == tag);
  assign hit    = word.valid && match;
  assign vdirty = word.valid && word.dirty && !match;
endmodule

// File: rtl/l2_seq.sv
module l2_seq
  import l2_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                req_we,
  input  logic                cfg_wb,
  input  logic                cacheable,
  input  logic                wprot,
  input  logic                hit,
  input  logic                vdirty,
  input  logic [L2_TAG_W-1:0] req_tag,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ADDR_W-1:0]   line_addr,
  input  logic [ADDR_W-1:0]   vict_addr,
  input  logic                mem_ack,
  output logic                cpu_ready,
  output logic                tag_re,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                tag_we,
  output tag_word_t           tag_wdata,
  output logic                mem_req,
  output mem_op_e             mem_op,
  output logic [ADDR_W-1:0]   mem_addr
);
  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] ma_q, ma_d;
  logic              twen_q, twen_d;
  tag_word_t         tw_q, tw_d;
  logic              hit_q, hit_d;
  logic              ld_en;

  always_comb begin
    st_d   = st_q;
    ma_d   = ma_q;
    twen_d = twen_q;
    tw_d   = tw_q;
    hit_d  = hit_q;
    unique case (st_q)
      ST_IDLE: if (cpu_req) st_d = ST_LOOK;
      ST_LOOK: begin
        hit_d  = cacheable && hit;
        twen_d = 1'b0;
        if (req_we && wprot) begin
          st_d = ST_RESP;
        end else if (!cacheable) begin
          ma_d = req_addr;
          st_d = req_we ? ST_MWR : ST_MRD;
        end else if (req_we) begin
          if (hit && cfg_wb) begin
            twen_d = 1'b1;
            tw_d   = '{valid: 1'b1, dirty: 1'b1, tag: req_tag};
            st_d   = ST_RESP;
          end else begin
            ma_d = req_addr;
            st_d = ST_MWR;
          end
        end else if (hit) begin
          st_d = ST_RESP;
        end else if (vdirty) begin
          ma_d = vict_addr;
          st_d = ST_EVICT;
        end else begin
          ma_d = line_addr;
          st_d = ST_FILL;
        end
      end
      ST_EVICT: if (mem_ack) begin
        ma_d = line_addr;
        st_d = ST_FILL;
      end
      ST_FILL: if (mem_ack) begin
        twen_d = 1'b1;
        tw_d   = '{valid: 1'b1, dirty: 1'b0, tag: req_tag};
        st_d   = ST_RESP;
      end
      ST_MRD, ST_MWR: if (mem_ack) st_d = ST_RESP;
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ld_en = (st_q == ST_LOOK) || mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_q   <= '0;
      twen_q <= 1'b0;
      tw_q   <= '0;
      hit_q  <= 1'b0;
    end else if (ld_en) begin
      ma_q   <= ma_d;
      twen_q <= twen_d;
      tw_q   <= tw_d;
      hit_q  <= hit_d;
    end
  end

  assign cpu_ready = (st_q == ST_IDLE);
  assign tag_re    = cpu_ready && cpu_req;
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_hit   = rsp_valid && hit_q;
  assign tag_we    = rsp_valid && twen_q;
  assign tag_wdata = tw_q;
  assign mem_addr  = ma_q;
  assign mem_req   = (st_q == ST_EVICT) || (st_q == ST_FILL) ||
                     (st_q == ST_MRD)   || (st_q == ST_MWR);

  always_comb begin
    unique case (st_q)
      ST_EVICT: mem_op = MOP_EVICT;
      ST_FILL:  mem_op = MOP_FILL;
      ST_MWR:   mem_op = MOP_WR;
      default:  mem_op = MOP_RD;
    endcase
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req && !tag_we);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_op) && $stable(mem_addr));

  a_r5_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_op == MOP_EVICT && mem_ack |=> mem_req && mem_op == MOP_FILL);

  a_r3_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> cpu_ready && !rsp_valid);

  a_r9_wp_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> !(req_we && wprot));

  a_r8_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we && req_we |-> tag_wdata.dirty && cfg_wb);

  a_r10_uncached_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> cacheable);
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import l2_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MIN_IW = 13,
  parameter int NSIZE  = 4,
  localparam int MAX_IW = MIN_IW + NSIZE - 1,
  localparam int SZ_W   = $clog2(NSIZE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SZ_W-1:0]      cfg_size,
  input  logic                 cfg_wb,
  input  logic [ADDR_W-1:0]    cfg_cache_lim,
  input  logic [ADDR_W-1:0]    cfg_wp_lo,
  input  logic [ADDR_W-1:0]    cfg_wp_hi,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  output logic                 cpu_ready,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [MAX_IW-1:0]    tag_addr,
  output logic                 tag_re,
  input  logic [L2_WORD_W-1:0] tag_rdata,
  output logic                 tag_we,
  output logic [L2_WORD_W-1:0] tag_wdata,
  output logic                 mem_req,
  output logic [1:0]           mem_op,
  input  logic                 mem_ack,
  output logic [ADDR_W-1:0]    mem_addr
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [ADDR_W-1:0]   req_addr_q;
  logic                req_we_q;
  logic                acc_en;
  logic [ADDR_W-1:0]   sel_addr;
  logic [L2_TAG_W-1:0] sel_tag;
  logic [ADDR_W-1:0]   line_addr, vict_addr;
  logic                cacheable, wprot, hit, vdirty;
  tag_word_t           rword, wword;
  mem_op_e             op_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign acc_en = cpu_req && cpu_ready;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      req_addr_q <= '0;
      req_we_q   <= 1'b0;
    end else if (acc_en) begin
      req_addr_q <= cpu_addr;
      req_we_q   <= cpu_we;
    end
  end

  // while idle the index follows the incoming address, otherwise the held one
  assign sel_addr = cpu_ready ? cpu_addr : req_addr_q;
  assign rword    = tag_word_t'(tag_rdata);

  l2_addr_split #(
    .ADDR_W(ADDR_W), .MIN_IW(MIN_IW), .NSIZE(NSIZE)
  ) i_split (
    .addr      (sel_addr),
    .size      (cfg_size),
    .lim       (cfg_cache_lim),
    .wp_lo     (cfg_wp_lo),
    .wp_hi     (cfg_wp_hi),
    .vtag      (rword.tag),
    .idx       (tag_addr),
    .tag       (sel_tag),
    .line_addr (line_addr),
    .vict_addr (vict_addr),
    .cacheable (cacheable),
    .wprot     (wprot)
  );

  l2_tag_cmp i_cmp (
    .word   (rword),
    .tag    (sel_tag),
    .hit    (hit),
    .vdirty (vdirty)
  );

  l2_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cpu_req   (cpu_req),
    .req_we    (req_we_q),
    .cfg_wb    (cfg_wb),
    .cacheable (cacheable),
    .wprot     (wprot),
    .hit       (hit),
    .vdirty    (vdirty),
    .req_tag   (sel_tag),
    .req_addr  (req_addr_q),
    .line_addr (line_addr),
    .vict_addr (vict_addr),
    .mem_ack   (mem_ack),
    .cpu_ready (cpu_ready),
    .tag_re    (tag_re),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .tag_we    (tag_we),
    .tag_wdata (wword),
    .mem_req   (mem_req),
    .mem_op    (op_e),
    .mem_addr  (mem_addr)
  );

  assign tag_wdata = wword;
  assign mem_op    = op_e;

  a_r7_wt_clean: assert property (@(posedge clk) disable iff (!rst_int_n)
    tag_we && tag_wdata[L2_TAG_W] |-> cfg_wb && req_we_q);
endmodule

// File: tb/test_l2_tag_ctrl.sv
module test_l2_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_size;
  logic        cfg_wb;
  logic [31:0] cfg_cache_lim, cfg_wp_lo, cfg_wp_hi;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr;
  logic        cpu_ready, rsp_valid, rsp_hit;
  logic [15:0] tag_addr;
  logic        tag_re, tag_we;
  logic [11:0] tag_rdata, tag_wdata;
  logic        mem_req, mem_ack;
  logic [1:0]  mem_op;
  logic [31:0] mem_addr;

  int total = 0;
  int bad   = 0;

  logic [11:0] tram [int];
  logic [11:0] rmod [int];

  int          e_nops;
  logic [1:0]  e_op [2];
  logic [31:0] e_addr [2];
  bit          e_tw, e_hit;
  logic [11:0] e_twd;
  logic [15:0] e_idx;

  always #10 clk = ~clk;

  l2_tag_ctrl i_l2_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_wb(cfg_wb),
    .cfg_cache_lim(cfg_cache_lim), .cfg_wp_lo(cfg_wp_lo), .cfg_wp_hi(cfg_wp_hi),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .tag_addr(tag_addr), .tag_re(tag_re), .tag_rdata(tag_rdata),
    .tag_we(tag_we), .tag_wdata(tag_wdata),
    .mem_req(mem_req), .mem_op(mem_op), .mem_ack(mem_ack), .mem_addr(mem_addr)
  );

  // external tag RAM model, one cycle read latency
  always @(posedge clk) begin
    if (tag_re) tag_rdata <= tram.exists(int'(tag_addr)) ? tram[int'(tag_addr)] : 12'h0;
    if (tag_we) tram[int'(tag_addr)] = tag_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void add_op(input logic [1:0] op, input logic [31:0] a);
    e_op[e_nops]   = op;
    e_addr[e_nops] = a;
    e_nops++;
  endfunction

  function automatic int cur_iw();
    return 12 + int'(cfg_size);
  endfunction

  function automatic void predict(input bit we, input logic [31:0] a);
    int iw;
    logic [31:0] idx;
    logic [9:0]  tg;
    logic [11:0] w;
    bit cach, wp, hit;
    e_nops = 0; e_tw = 0; e_twd = '0;
    if (cfg_size >= 3'd1 && cfg_size <= 3'd4) begin
      iw   = cur_iw();
      cach = ((a >> (15 + iw)) == 32'd0) && (a < cfg_cache_lim);
      idx  = (a >> 5) & ((32'd1 << iw) - 32'd1);
      tg   = 10'((a >> (5 + iw)) & 32'h3ff);
    end else begin
      iw = 13; cach = 0; idx = 0; tg = '0;
    end
    e_idx = 16'(idx);
    wp = (a >= cfg_wp_lo) && (a < cfg_wp_hi);
    w  = rmod.exists(int'(idx)) ? rmod[int'(idx)] : 12'h0;
    hit = cach && w[11] && (w[9:0] == tg);
    e_hit = hit;
    if (we && wp) begin
    end else if (!cach) begin
      add_op(we ? 2'd1 : 2'd0, a);
    end else if (we) begin
      if (hit && cfg_wb) begin e_tw = 1; e_twd = {2'b11, tg}; end
      else add_op(2'd1, a);
    end else if (!hit) begin
      if (w[11] && w[10]) add_op(2'd3, ((32'(w[9:0]) << iw) | idx) << 5);
      add_op(2'd2, a & ~32'd31);
      e_tw = 1; e_twd = {2'b10, tg};
    end
    if (e_tw) rmod[int'(idx)] = e_twd;
  endfunction

  task automatic txn(input bit we, input logic [31:0] a);
    int cyc, nreq, wcnt;
    bit in_req, ack_drv, done, tw_seen;
    logic [1:0]  cur_op;
    logic [31:0] cur_addr;
    logic [11:0] got, want;
    predict(we, a);
    @(negedge clk);
    chk(cpu_ready, "R1 ready before request", 32'(cpu_ready), 32'd1);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    #1;
    chk(tag_re && tag_addr == e_idx, "R2 tag index", 32'(tag_addr), 32'(e_idx));
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1; nreq = 0; wcnt = 0; in_req = 0; ack_drv = 0; done = 0; tw_seen = 0;
    cur_op = '0; cur_addr = '0;
    while (!done && cyc < 60) begin
      if (ack_drv) begin mem_ack = 1'b0; ack_drv = 0; in_req = 0; end
      if (rsp_valid) begin
        done = 1;
        chk(rsp_hit == e_hit, "R3 R10 hit flag", 32'(rsp_hit), 32'(e_hit));
        if (e_nops == 0)
          chk(cyc == 2, "R3 response latency", 32'(cyc), 32'd2);
        if (tag_we) begin
          tw_seen = 1;
          chk(tag_wdata == e_twd, "R4 R6 tag word", 32'(tag_wdata), 32'(e_twd));
        end
      end else if (mem_req) begin
        if (!in_req) begin
          in_req = 1; cur_op = mem_op; cur_addr = mem_addr;
          if (nreq < e_nops) begin
            chk(mem_op == e_op[nreq], "R5 R7 R8 R10 mem op", 32'(mem_op), 32'(e_op[nreq]));
            chk(mem_addr == e_addr[nreq], "R4 R5 mem addr", mem_addr, e_addr[nreq]);
          end else begin
            chk(0, "R6 R9 unexpected mem request", 32'(mem_op), 32'hffff_ffff);
          end
          nreq++;
          wcnt = $urandom_range(0, 2);
        end else begin
          chk(mem_op == cur_op && mem_addr == cur_addr, "R11 request held", mem_addr, cur_addr);
        end
        if (wcnt == 0) begin mem_ack = 1'b1; ack_drv = 1; end
        else wcnt--;
      end
      if (!done) begin @(negedge clk); cyc++; end
    end
    chk(done, "R11 response arrives", 32'(cyc), 32'd60);
    chk(nreq == e_nops, "R4 R5 request count", 32'(nreq), 32'(e_nops));
    chk(tw_seen == e_tw, "R7 R8 R9 tag write presence", 32'(tw_seen), 32'(e_tw));
    @(negedge clk);
    got  = tram.exists(int'(e_idx)) ? tram[int'(e_idx)] : 12'h0;
    want = rmod.exists(int'(e_idx)) ? rmod[int'(e_idx)] : 12'h0;
    chk(got == want, "R2 stored tag word", 32'(got), 32'(want));
  endtask

  task automatic flush();
    tram.delete();
    rmod.delete();
  endtask

  function automatic logic [31:0] gen_addr(input int iw);
    logic [31:0] idx, tg;
    int r;
    r = $urandom_range(0, 15);
    if (r == 0) return $urandom;
    case ($urandom_range(0, 3))
      0: idx = 0;
      1: idx = 1;
      2: idx = 5;
      default: idx = (32'd1 << iw) - 1;
    endcase
    case ($urandom_range(0, 3))
      0: tg = 0;
      1: tg = 1;
      2: tg = 2;
      default: tg = 32'h3ff;
    endcase
    return (tg << (5 + iw)) | (idx << 5) | 32'($urandom_range(0, 31));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    int iw;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; mem_ack = 1'b0;
    cfg_size = 3'd1; cfg_wb = 1'b1; cfg_cache_lim = 32'hffff_ffff;
    cfg_wp_lo = '0; cfg_wp_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_ready && !rsp_valid && !mem_req && !tag_we, "R1 reset state",
        {28'd0, cpu_ready, rsp_valid, mem_req, tag_we}, 32'h8);

    // directed: fill, hit, dirty, eviction
    a = 32'h0000_1000;
    b = a | (32'd1 << 18);
    txn(0, a);                 // R4 clean miss fill
    txn(0, a);                 // R3 hit
    txn(1, a);                 // R6 write-back hit dirties
    txn(0, b);                 // R5 evict then fill
    txn(1, a);                 // R8 write miss, no allocate
    cfg_wb = 1'b0;
    txn(1, b);                 // R7 write-through hit
    cfg_wp_lo = b & ~32'hff; cfg_wp_hi = cfg_wp_lo + 32'h100;
    txn(1, b);                 // R9 discarded write
    txn(0, b);                 // R9 read in window still hits
    cfg_wp_lo = '0; cfg_wp_hi = '0;
    cfg_size = 3'd0;
    txn(0, a);                 // R10 disabled cache, single read
    txn(1, a);                 // R10 disabled cache, single write
    cfg_size = 3'd4;
    txn(0, 32'h8000_0040);     // R10 above tag reach
    cfg_cache_lim = 32'h0010_0000;
    txn(0, 32'h0020_0000);     // R10 above cacheable limit
    cfg_cache_lim = 32'hffff_ffff;

    // random per size code
    for (int s = 1; s <= 5; s++) begin
      cfg_size = (s == 5) ? 3'd0 : 3'(s);
      flush();
      iw = (s == 5) ? 13 : 12 + s;
      for (int n = 0; n < 220; n++) begin
        cfg_wb = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 3) == 0) begin
          cfg_wp_lo = 32'd1 << (5 + iw);
          cfg_wp_hi = 32'd2 << (5 + iw);
        end else begin
          cfg_wp_lo = '0; cfg_wp_hi = '0;
        end
        cfg_cache_lim = ($urandom_range(0, 4) == 0) ? (32'h200 << (5 + iw)) : 32'hffff_ffff;
        txn(1'($urandom_range(0, 1)), gen_addr(iw));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule